// File: doc/BRIEF.md
# String and Loop Count Sequencer

This block is the control datapath behind repeated string transfers and counted loops in a 16-bit segmented processor. It holds a source index, a destination index and an element counter. For each element it presents a 20-bit source address, built from the data segment base and the source index, and a 20-bit destination address, built from the extra segment base and the destination index. On each accepted step request it moves both indices by one element, either up or down, and decrements the counter.

An operation begins with a start pulse that loads the two indices and the count. The same pulse captures the direction bit, the element size (byte or word) and the repeat mode. The operation then runs one element per step request. It ends when the counter reaches zero. In the two compare-style repeat modes it also ends when the zero flag supplied with the step fails the mode's condition. The end is marked by a one-cycle done pulse, and busy falls at the same time. Memory access, decode and interrupts are handled elsewhere.

Top module: `strseq_top`

## Requirements
- R1: After reset, busy, done, count, src_idx and dst_idx are all zero.
- R2: A start while idle with a nonzero cnt_load loads src_load, dst_load and cnt_load and raises busy one cycle later, with done low.
- R3: A start while idle with cnt_load equal to zero performs no transfer. One cycle later done is high for one cycle, busy stays low, and the indices hold the loaded values.
- R4: src_addr equals data_seg*16 + src_idx modulo 2^20, and dst_addr equals extra_seg*16 + dst_idx modulo 2^20.
- R5: Each step taken while busy moves both indices by 1 when wide=0 (byte) or by 2 when wide=1 (word). They increase when dir=0 and decrease when dir=1. Direction and size are the values captured at start.
- R6: Index arithmetic wraps modulo 2^16 in both directions.
- R7: Each step taken while busy decrements count by one. The step that brings count to zero ends the operation.
- R8: With mode=1 (repeat while zero), a step whose zf is 0 ends the operation. With mode=2 (repeat while not zero), a step whose zf is 1 ends it. In both cases the decrement still occurs.
- R9: With mode=0 (plain transfer, and also for mode=3), zf has no effect on termination.
- R10: A step while idle changes no register, and a start while busy is ignored.
- R11: done is high for exactly one cycle after the step or start that ends the operation, busy is low in that cycle, and done is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| mode | input | 2 | Repeat mode: 0 plain, 1 while zero, 2 while not zero |
| dir | input | 1 | Direction: 0 increment, 1 decrement |
| wide | input | 1 | Element size: 0 byte, 1 word |
| zf | input | 1 | Zero flag from the element just processed, sampled with step |
| step | input | 1 | Element step request |
| src_load | input | 16 | Starting source index |
| dst_load | input | 16 | Starting destination index |
| cnt_load | input | 16 | Starting element count |
| data_seg | input | 16 | Data segment base for the source |
| extra_seg | input | 16 | Extra segment base for the destination |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| src_idx | output | 16 | Current source index |
| dst_idx | output | 16 | Current destination index |
| count | output | 16 | Current remaining count |
| src_addr | output | 20 | Source physical address |
| dst_addr | output | 20 | Destination physical address |

## Verification
Indices, count, busy and done are registered. Each of them shows the effect of a start or step exactly one clock edge after that input is sampled. The two addresses follow the current index and segment inputs combinationally, in the same cycle. The bench drives inputs on the falling edge and checks every registered result on the next falling edge, so each check lands half a period after the edge that produced the result. It also checks done low one cycle later to confirm the pulse width. The sweep covers both directions, both element sizes, all three modes, several counts including zero, and start indices at the wrap points, with the expected values worked out arithmetically in the bench.

// File: rtl/strseq_pkg.sv
package strseq_pkg;
   typedef enum logic [1:0] {
      RPT_PLAIN    = 2'd0,
      RPT_WHILE_Z  = 2'd1,
      RPT_WHILE_NZ = 2'd2,
      RPT_RSVD     = 2'd3
   } rpt_mode_e;
endpackage

// File: rtl/strseq_index_reg.sv
module strseq_index_reg #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             adv,
   input  logic             dir,
   input  logic             wide,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] BYTE_STEP = IDX_W'(1);
   localparam logic [IDX_W-1:0] WORD_STEP = IDX_W'(2);

   logic [IDX_W-1:0] delta;
   logic [IDX_W-1:0] nxt;

   always_comb begin
      delta = wide ? WORD_STEP : BYTE_STEP;
      nxt   = dir ? (idx - delta) : (idx + delta);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= load_val;
      else if (adv)  idx <= nxt;
   end

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(idx));
   assert_step_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> ((idx - $past(idx)) == BYTE_STEP || (idx - $past(idx)) == WORD_STEP
                       || ($past(idx) - idx) == BYTE_STEP || ($past(idx) - idx) == WORD_STEP));
endmodule

// File: rtl/strseq_count_term.sv
module strseq_count_term
   import strseq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] cnt_load,
   input  logic [1:0]       mode_in,
   input  logic             step,
   input  logic             zf,
   output logic             accept,
   output logic             adv,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] count
);
   rpt_mode_e        mode_q;
   logic [CNT_W-1:0] cnt_dec;
   logic             cond_fail;
   logic             stop;

   always_comb begin
      accept  = start && !busy;
      adv     = busy && step;
      cnt_dec = count - CNT_W'(1);
      unique case (mode_q)
         RPT_WHILE_Z:  cond_fail = !zf;
         RPT_WHILE_NZ: cond_fail = zf;
         default:      cond_fail = 1'b0;
      endcase
      stop = (cnt_dec == '0) || cond_fail;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         mode_q <= RPT_PLAIN;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else if (accept) begin
         count  <= cnt_load;
         mode_q <= rpt_mode_e'(mode_in);
         busy   <= (cnt_load != '0);
         done   <= (cnt_load == '0);
      end else if (adv) begin
         count  <= cnt_dec;
         busy   <= !stop;
         done   <= stop;
      end else begin
         done   <= 1'b0;
      end
   end

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_busy_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (count != '0));
   assert_zero_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cnt_load == '0) |=> (done && !busy));
   assert_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/strseq_addr_gen.sv
module strseq_addr_gen #(
   parameter int IDX_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = IDX_W + SEG_SHIFT
) (
   input  logic [IDX_W-1:0]  seg,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign addr = seg + idx;
      end else begin : g_shifted
         logic [ADDR_W-1:0] base;
         logic [ADDR_W-1:0] offs;
         assign base = {seg, {SEG_SHIFT{1'b0}}};
         assign offs = {{SEG_SHIFT{1'b0}}, idx};
         assign addr = base + offs;
      end
   endgenerate
endmodule

// File: rtl/strseq_top.sv
module strseq_top #(
   parameter int IDX_W     = 16,
   parameter int SEG_SHIFT = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [1:0]                 mode,
   input  logic                       dir,
   input  logic                       wide,
   input  logic                       zf,
   input  logic                       step,
   input  logic [IDX_W-1:0]           src_load,
   input  logic [IDX_W-1:0]           dst_load,
   input  logic [IDX_W-1:0]           cnt_load,
   input  logic [IDX_W-1:0]           data_seg,
   input  logic [IDX_W-1:0]           extra_seg,
   output logic                       busy,
   output logic                       done,
   output logic [IDX_W-1:0]           src_idx,
   output logic [IDX_W-1:0]           dst_idx,
   output logic [IDX_W-1:0]           count,
   output logic [IDX_W+SEG_SHIFT-1:0] src_addr,
   output logic [IDX_W+SEG_SHIFT-1:0] dst_addr
);
   localparam int ADDR_W = IDX_W + SEG_SHIFT;
   localparam int N_IDX  = 2;

   generate
      if (IDX_W < 4)      begin : g_bad_width $error("IDX_W must be at least 4"); end
      if (SEG_SHIFT < 0)  begin : g_bad_shift $error("SEG_SHIFT must not be negative"); end
   endgenerate

   logic accept;
   logic adv;
   logic dir_q;
   logic wide_q;

   logic [IDX_W-1:0]  ld_val [N_IDX];
   logic [IDX_W-1:0]  seg_v  [N_IDX];
   logic [IDX_W-1:0]  idx_v  [N_IDX];
   logic [ADDR_W-1:0] addr_v [N_IDX];

   assign ld_val[0] = src_load;
   assign ld_val[1] = dst_load;
   assign seg_v[0]  = data_seg;
   assign seg_v[1]  = extra_seg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= 1'b0;
         wide_q <= 1'b0;
      end else if (accept) begin
         dir_q  <= dir;
         wide_q <= wide;
      end
   end

   strseq_count_term #(.CNT_W(IDX_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .cnt_load(cnt_load),
      .mode_in(mode), .step(step), .zf(zf), .accept(accept), .adv(adv),
      .busy(busy), .done(done), .count(count)
   );

   generate
      for (genvar g = 0; g < N_IDX; g++) begin : g_lane
         strseq_index_reg #(.IDX_W(IDX_W)) u_idx (
            .clk(clk), .rst_n(rst_n), .load(accept), .load_val(ld_val[g]),
            .adv(adv), .dir(dir_q), .wide(wide_q), .idx(idx_v[g])
         );
         strseq_addr_gen #(.IDX_W(IDX_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_addr (
            .seg(seg_v[g]), .idx(idx_v[g]), .addr(addr_v[g])
         );
      end
   endgenerate

   assign src_idx  = idx_v[0];
   assign dst_idx  = idx_v[1];
   assign src_addr = addr_v[0];
   assign dst_addr = addr_v[1];

   assert_lanes_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !accept) |=> ((src_idx - $past(src_idx)) == (dst_idx - $past(dst_idx))));
   assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !step) |=> ($stable(count) && $stable(src_idx) && $stable(dst_idx)));
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (src_idx == $past(src_load) && dst_idx == $past(dst_load)));
endmodule

// File: tb/strseq_top_tb_top.sv
`timescale 1ns/1ps
module strseq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, dir = 1'b0, wide = 1'b0, zf = 1'b0, step = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [15:0] src_load = '0, dst_load = '0, cnt_load = '0, data_seg = '0, extra_seg = '0;
   logic        busy, done;
   logic [15:0] src_idx, dst_idx, count;
   logic [19:0] src_addr, dst_addr;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   strseq_top dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir), .wide(wide),
      .zf(zf), .step(step), .src_load(src_load), .dst_load(dst_load), .cnt_load(cnt_load),
      .data_seg(data_seg), .extra_seg(extra_seg), .busy(busy), .done(done),
      .src_idx(src_idx), .dst_idx(dst_idx), .count(count),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] idx);
      return {seg, 4'h0} + {4'h0, idx};
   endfunction

   task automatic chk_addr();
      chk("R4 src_addr", 32'(src_addr), 32'(phys(data_seg, src_idx)));
      chk("R4 dst_addr", 32'(dst_addr), 32'(phys(extra_seg, dst_idx)));
   endtask

   task automatic run_op(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                         input logic dv, input logic wv, input logic [1:0] mv, input int seed);
      logic [15:0] es, ed, ec, dl;
      es = s; ed = d; ec = c;
      dl = wv ? 16'd2 : 16'd1;
      @(negedge clk);
      start = 1'b1; src_load = s; dst_load = d; cnt_load = c; dir = dv; wide = wv; mode = mv;
      @(negedge clk);
      start = 1'b0; dir = ~dv; wide = ~wv; mode = 2'd0;
      if (c == 16'd0) begin
         chk("R3 done on zero count", 32'(done), 32'd1);
         chk("R3 busy on zero count", 32'(busy), 32'd0);
         chk("R3 src held", 32'(src_idx), 32'(s));
         chk("R3 dst held", 32'(dst_idx), 32'(d));
      end else begin
         chk("R2 busy", 32'(busy), 32'd1);
         chk("R2 done low", 32'(done), 32'd0);
         chk("R2 count", 32'(count), 32'(c));
         chk("R2 src", 32'(src_idx), 32'(s));
         chk("R2 dst", 32'(dst_idx), 32'(d));
         chk_addr();
         for (int k = 0; k < 40; k++) begin
            logic z, stop, wrap;
            string tg;
            z = (((k + seed) % 3) == 2);
            step = 1'b1; zf = z;
            @(negedge clk);
            step = 1'b0; zf = ~z;
            wrap = dv ? (es < dl) : (es > 16'hFFFF - dl);
            es = dv ? es - dl : es + dl;
            ed = dv ? ed - dl : ed + dl;
            ec = ec - 16'd1;
            stop = (ec == 16'd0) || (mv == 2'd1 && !z) || (mv == 2'd2 && z);
            tg = wrap ? "R6 src wrap" : "R5 src step";
            chk(tg, 32'(src_idx), 32'(es));
            chk("R5 dst step", 32'(dst_idx), 32'(ed));
            chk("R7 count", 32'(count), 32'(ec));
            if (ec == 16'd0)      tg = "R7 done at zero";
            else if (mv == 2'd0 || mv == 2'd3) tg = "R9 zf ignored";
            else                  tg = "R8 zf condition";
            chk(tg, 32'(done), 32'(stop));
            chk("R11 busy vs done", 32'(busy), 32'(!stop));
            chk_addr();
            if (stop) break;
         end
      end
      @(negedge clk);
      chk("R11 done one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 count", 32'(count), 32'd0);
      chk("R1 src", 32'(src_idx), 32'd0);
      chk("R1 dst", 32'(dst_idx), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int seed = 0; seed < 3; seed++) begin
         for (int dv = 0; dv < 2; dv++) begin
            for (int wv = 0; wv < 2; wv++) begin
               for (int mv = 0; mv < 4; mv++) begin
                  for (int ci = 0; ci < 5; ci++) begin
                     logic [15:0] c, s, d;
                     c = (ci == 4) ? 16'd7 : 16'(ci);
                     s = (seed == 0) ? 16'h0000 : (seed == 1) ? 16'hFFFF : 16'h1234;
                     d = (seed == 0) ? 16'hFFFE : (seed == 1) ? 16'h0001 : 16'h8000;
                     data_seg  = 16'hF000 + 16'(seed) * 16'h0111;
                     extra_seg = 16'hFFFF - 16'(seed);
                     run_op(s, d, c, dv[0], wv[0], 2'(mv), seed + ci);
                  end
               end
            end
         end
      end

      // R10: step while idle leaves state unchanged
      begin
         logic [15:0] s0, d0, c0;
         s0 = src_idx; d0 = dst_idx; c0 = count;
         step = 1'b1; zf = 1'b1;
         repeat (2) @(negedge clk);
         step = 1'b0;
         chk("R10 idle step src", 32'(src_idx), 32'(s0));
         chk("R10 idle step dst", 32'(dst_idx), 32'(d0));
         chk("R10 idle step count", 32'(count), 32'(c0));
         chk("R10 idle step busy", 32'(busy), 32'd0);
      end

      // R10: start while busy is ignored
      @(negedge clk);
      start = 1'b1; src_load = 16'h0100; dst_load = 16'h0200; cnt_load = 16'd5;
      dir = 1'b0; wide = 1'b0; mode = 2'd0;
      @(negedge clk);
      src_load = 16'h5555; dst_load = 16'h6666; cnt_load = 16'd9;
      @(negedge clk);
      start = 1'b0;
      chk("R10 busy start count", 32'(count), 32'd5);
      chk("R10 busy start src", 32'(src_idx), 32'h0100);
      chk("R10 busy start dst", 32'(dst_idx), 32'h0200);
      step = 1'b1;
      repeat (5) @(negedge clk);
      step = 1'b0;
      chk("R7 final count", 32'(count), 32'd0);
      chk("R11 final done", 32'(done), 32'd1);
      chk("R5 final src", 32'(src_idx), 32'h0105);
      @(negedge clk);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule